// File: doc/BRIEF.md
# Dual-Issue Asymmetric Instruction Steering

This block sits between fetch and two execution pipes of unequal capability. Every cycle it is offered a pair of consecutive instructions: the older in slot 0 and the younger in slot 1, fetched together from PC and PC+4. It assigns each word a class from its opcode and routes the pair onto pipe A, which takes integer and branch work, and pipe B, which takes integer and memory work. The slots are crossed over whenever that is what lets the pair issue.

When the pair cannot go together, only the older instruction issues. The younger is left for fetch to present again as the next slot 0. Three things stop the pair: both instructions want the same pipe, the younger reads a register the older writes, or the older is a branch. A consumed count of 0, 1 or 2 goes back to fetch so the PC can advance by 0, 4 or 8 bytes.

The routed words and their valid bits are registered. Each pipe's decoder therefore sees them at the start of the next cycle, and both decoders work in parallel.

Top module: `steer_dual_issue`

## Requirements
- R1: The class comes from bits [6:0]. Opcodes 7'b0110011 and 7'b0010011 are integer (2'b00), 7'b1100011 is branch (2'b01), and 7'b0000011 (load) and 7'b0100011 (store) are memory (2'b10). Every other opcode is nop (2'b11). A nop in slot 0 is counted as consumed but drives no pipe.
- R2: Pipe A never receives a memory instruction. Pipe B never receives a branch.
- R3: An issuing slot 0 goes to pipe B when it is memory and to pipe A when it is a branch. An integer slot 0 goes to pipe A, except when a branch in slot 1 issues beside it: then slot 0 goes to pipe B and slot 1 goes to pipe A.
- R4: Two integer instructions issue together, slot 0 on pipe A and slot 1 on pipe B. An integer slot 1 takes the pipe slot 0 leaves free, and takes pipe A when slot 0 is a nop.
- R5: When both slots are memory, or both are branches, only slot 0 issues.
- R6: Slot 0 writes its rd field [11:7] when it is integer or a load and rd is nonzero. Slot 1 reads rs1 [19:15] unless it is a nop. It also reads rs2 [24:20] when its opcode is 7'b0110011, 7'b1100011 or 7'b0100011. If slot 1 reads a register that slot 0 writes, only slot 0 issues.
- R7: Slot 1 never issues without slot 0. With slot 0 invalid the count is 0. With slot 0 a branch the count is at most 1.
- R8: With ready low the count is 0 and neither pipe valid is set in the next cycle. The value 3 never appears on the count.
- R9: Pipe words and valid bits are registered: they reflect the pair offered in the previous cycle. Reset clears both valid bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| inst0_i | input | ILEN | Older instruction word (slot 0) |
| inst0_valid_i | input | 1 | Slot 0 holds an instruction |
| inst1_i | input | ILEN | Younger instruction word (slot 1) |
| inst1_valid_i | input | 1 | Slot 1 holds an instruction |
| ready_i | input | 1 | Both pipes can accept this cycle |
| pipe_a_inst_o | output | ILEN | Word routed to pipe A |
| pipe_a_valid_o | output | 1 | Pipe A word is live |
| pipe_b_inst_o | output | ILEN | Word routed to pipe B |
| pipe_b_valid_o | output | 1 | Pipe B word is live |
| consumed_o | output | 2 | Instructions taken this cycle (0, 1 or 2) |

## Verification
The assertions watch, on every cycle, for a memory opcode on pipe A, a branch on pipe B, a count of 2 beside a branch or a memory pair, a nonzero count with ready low or slot 0 invalid, and live pipe outputs after a cycle that took nothing. They cannot show that the pair is crossed correctly, that a register dependency stops slot 1, or that the right word reaches each pipe. Only the bench's sweep shows those, since it compares every class pair, valid pattern, ready value and register overlap against counts and routes computed on its own.

// File: rtl/steer_pkg.sv
package steer_pkg;
  typedef enum logic [1:0] {
    CLS_INT = 2'b00,
    CLS_BR  = 2'b01,
    CLS_MEM = 2'b10,
    CLS_NOP = 2'b11
  } iclass_e;

  localparam int unsigned OPC_W = 7;
  localparam int unsigned REG_W = 5;
  localparam int unsigned RD_LSB  = 7;
  localparam int unsigned RS1_LSB = 15;
  localparam int unsigned RS2_LSB = 20;
  localparam int unsigned MIN_ILEN = RS2_LSB + REG_W;

  localparam logic [OPC_W-1:0] OPC_ALU_RR = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_ALU_RI = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;

  // older instruction produces a register result
  function automatic logic writes_rd(input logic [OPC_W-1:0] opc);
    return (opc == OPC_ALU_RR) || (opc == OPC_ALU_RI) || (opc == OPC_LOAD);
  endfunction

  // younger instruction sources its second register
  function automatic logic reads_rs2(input logic [OPC_W-1:0] opc);
    return (opc == OPC_ALU_RR) || (opc == OPC_BRANCH) || (opc == OPC_STORE);
  endfunction
endpackage

// File: rtl/steer_classify.sv
module steer_classify
  import steer_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  output iclass_e          cls_o
);
  always_comb begin
    unique case (opc_i)
      OPC_ALU_RR, OPC_ALU_RI: cls_o = CLS_INT;
      OPC_BRANCH:             cls_o = CLS_BR;
      OPC_LOAD, OPC_STORE:    cls_o = CLS_MEM;
      default:                cls_o = CLS_NOP;
    endcase
  end
endmodule

// File: rtl/steer_pair_check.sv
module steer_pair_check
  import steer_pkg::*;
(
  input  iclass_e          cls0_i,
  input  iclass_e          cls1_i,
  input  logic [OPC_W-1:0] opc0_i,
  input  logic [OPC_W-1:0] opc1_i,
  input  logic [REG_W-1:0] rd0_i,
  input  logic [REG_W-1:0] rs1_1_i,
  input  logic [REG_W-1:0] rs2_1_i,
  input  logic             valid0_i,
  input  logic             valid1_i,
  input  logic             ready_i,
  output logic             issue0_o,
  output logic             issue1_o,
  output logic [1:0]       consumed_o
);
  logic wr0, raw_hit, pipe_clash, order_stop;

  assign wr0 = writes_rd(opc0_i) && (rd0_i != '0);

  always_comb begin
    raw_hit = 1'b0;
    if (wr0) begin
      if (cls1_i != CLS_NOP && rs1_1_i == rd0_i) raw_hit = 1'b1;
      if (reads_rs2(opc1_i) && rs2_1_i == rd0_i)  raw_hit = 1'b1;
    end
  end

  // both want the single pipe that can run them
  assign pipe_clash = (cls0_i == cls1_i) && (cls0_i == CLS_BR || cls0_i == CLS_MEM);
  assign order_stop = (cls0_i == CLS_BR);

  assign issue0_o = ready_i && valid0_i;
  assign issue1_o = issue0_o && valid1_i && !raw_hit && !pipe_clash && !order_stop;
  assign consumed_o = {1'b0, issue0_o} + {1'b0, issue1_o};
endmodule

// File: rtl/steer_route.sv
module steer_route
  import steer_pkg::*;
#(
  parameter int unsigned ILEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  iclass_e         cls0_i,
  input  iclass_e         cls1_i,
  input  logic            issue0_i,
  input  logic            issue1_i,
  input  logic [ILEN-1:0] inst0_i,
  input  logic [ILEN-1:0] inst1_i,
  output logic [ILEN-1:0] a_inst_o,
  output logic            a_valid_o,
  output logic [ILEN-1:0] b_inst_o,
  output logic            b_valid_o
);
  logic s0_a, s0_b, s1_a, s1_b;

  always_comb begin
    s0_a = 1'b0;
    s0_b = 1'b0;
    if (issue0_i) begin
      unique case (cls0_i)
        CLS_BR:  s0_a = 1'b1;
        CLS_MEM: s0_b = 1'b1;
        CLS_INT: begin
          if (issue1_i && cls1_i == CLS_BR) s0_b = 1'b1;
          else                              s0_a = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    s1_a = 1'b0;
    s1_b = 1'b0;
    if (issue1_i) begin
      unique case (cls1_i)
        CLS_BR:  s1_a = 1'b1;
        CLS_MEM: s1_b = 1'b1;
        CLS_INT: begin
          if (s0_a) s1_b = 1'b1;
          else      s1_a = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_valid_o <= 1'b0;
      b_valid_o <= 1'b0;
      a_inst_o  <= '0;
      b_inst_o  <= '0;
    end else begin
      a_valid_o <= s0_a || s1_a;
      b_valid_o <= s0_b || s1_b;
      a_inst_o  <= s1_a ? inst1_i : inst0_i;
      b_inst_o  <= s1_b ? inst1_i : inst0_i;
    end
  end
endmodule

// File: rtl/steer_dual_issue.sv
module steer_dual_issue
  import steer_pkg::*;
#(
  parameter int unsigned ILEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ILEN-1:0] inst0_i,
  input  logic            inst0_valid_i,
  input  logic [ILEN-1:0] inst1_i,
  input  logic            inst1_valid_i,
  input  logic            ready_i,
  output logic [ILEN-1:0] pipe_a_inst_o,
  output logic            pipe_a_valid_o,
  output logic [ILEN-1:0] pipe_b_inst_o,
  output logic            pipe_b_valid_o,
  output logic [1:0]      consumed_o
);
  localparam int unsigned NSLOT = 2;

  logic [NSLOT-1:0][ILEN-1:0] slot_inst;
  iclass_e                    slot_cls [NSLOT];
  logic                       issue0, issue1;

  assign slot_inst[0] = inst0_i;
  assign slot_inst[1] = inst1_i;

  for (genvar s = 0; s < NSLOT; s++) begin : g_cls
    steer_classify u_cls (
      .opc_i (slot_inst[s][OPC_W-1:0]),
      .cls_o (slot_cls[s])
    );
  end

  steer_pair_check u_pair (
    .cls0_i     (slot_cls[0]),
    .cls1_i     (slot_cls[1]),
    .opc0_i     (inst0_i[OPC_W-1:0]),
    .opc1_i     (inst1_i[OPC_W-1:0]),
    .rd0_i      (inst0_i[RD_LSB +: REG_W]),
    .rs1_1_i    (inst1_i[RS1_LSB +: REG_W]),
    .rs2_1_i    (inst1_i[RS2_LSB +: REG_W]),
    .valid0_i   (inst0_valid_i),
    .valid1_i   (inst1_valid_i),
    .ready_i    (ready_i),
    .issue0_o   (issue0),
    .issue1_o   (issue1),
    .consumed_o (consumed_o)
  );

  steer_route #(.ILEN(ILEN)) u_route (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cls0_i    (slot_cls[0]),
    .cls1_i    (slot_cls[1]),
    .issue0_i  (issue0),
    .issue1_i  (issue1),
    .inst0_i   (inst0_i),
    .inst1_i   (inst1_i),
    .a_inst_o  (pipe_a_inst_o),
    .a_valid_o (pipe_a_valid_o),
    .b_inst_o  (pipe_b_inst_o),
    .b_valid_o (pipe_b_valid_o)
  );
endmodule

// File: rtl/steer_dual_issue_chk.sv
module steer_dual_issue_chk
  import steer_pkg::*;
#(
  parameter int unsigned ILEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [ILEN-1:0] inst0_i,
  input logic            inst0_valid_i,
  input logic [ILEN-1:0] inst1_i,
  input logic            ready_i,
  input logic [ILEN-1:0] pipe_a_inst_o,
  input logic            pipe_a_valid_o,
  input logic [ILEN-1:0] pipe_b_inst_o,
  input logic            pipe_b_valid_o,
  input logic [1:0]      consumed_o
);
  logic a_is_mem, b_is_br, s0_br, pair_mem;
  assign a_is_mem = pipe_a_inst_o[OPC_W-1:0] == OPC_LOAD || pipe_a_inst_o[OPC_W-1:0] == OPC_STORE;
  assign b_is_br  = pipe_b_inst_o[OPC_W-1:0] == OPC_BRANCH;
  assign s0_br    = inst0_i[OPC_W-1:0] == OPC_BRANCH;
  assign pair_mem = (inst0_i[OPC_W-1:0] == OPC_LOAD || inst0_i[OPC_W-1:0] == OPC_STORE) &&
                    (inst1_i[OPC_W-1:0] == OPC_LOAD || inst1_i[OPC_W-1:0] == OPC_STORE);

  // R2
  a_no_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pipe_a_valid_o |-> !a_is_mem);
  // R2
  b_no_branch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pipe_b_valid_o |-> !b_is_br);
  // R5
  mem_pair_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_mem |-> consumed_o != 2'd2);
  // R7
  branch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inst0_valid_i && s0_br) |-> consumed_o != 2'd2);
  // R7
  slot0_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inst0_valid_i |-> consumed_o == 2'd0);
  // R8
  not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |-> consumed_o == 2'd0);
  // R8
  count_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consumed_o != 2'd3);
  // R8
  idle_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consumed_o == 2'd0 |=> !pipe_a_valid_o && !pipe_b_valid_o);
endmodule

bind steer_dual_issue steer_dual_issue_chk #(.ILEN(ILEN)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .inst0_i        (inst0_i),
  .inst0_valid_i  (inst0_valid_i),
  .inst1_i        (inst1_i),
  .ready_i        (ready_i),
  .pipe_a_inst_o  (pipe_a_inst_o),
  .pipe_a_valid_o (pipe_a_valid_o),
  .pipe_b_inst_o  (pipe_b_inst_o),
  .pipe_b_valid_o (pipe_b_valid_o),
  .consumed_o     (consumed_o)
);

// File: tb/tb_steer_dual_issue.sv
module tb_steer_dual_issue;
  localparam int unsigned ILEN = 32;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [ILEN-1:0] inst0_i = '0, inst1_i = '0;
  logic            inst0_valid_i = 1'b0, inst1_valid_i = 1'b0, ready_i = 1'b0;
  logic [ILEN-1:0] pipe_a_inst_o, pipe_b_inst_o;
  logic            pipe_a_valid_o, pipe_b_valid_o;
  logic [1:0]      consumed_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  steer_dual_issue #(.ILEN(ILEN)) dut (.*);

  // opcodes: int rr, int imm, branch, load, store, other (nop)
  function automatic logic [6:0] opc_at(int k);
    case (k)
      0: return 7'b0110011;
      1: return 7'b0010011;
      2: return 7'b1100011;
      3: return 7'b0000011;
      4: return 7'b0100011;
      default: return 7'b0001111;
    endcase
  endfunction

  function automatic int cls_at(int k);
    case (k)
      0, 1: return 0;
      2: return 1;
      3, 4: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [ILEN-1:0] mk(logic [6:0] opc, logic [4:0] rd, logic [4:0] rs1, logic [4:0] rs2);
    return {7'h0, rs2, rs1, 3'b000, rd, opc};
  endfunction

  task automatic chk(bit ok, string tag, logic [ILEN-1:0] act, logic [ILEN-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    #12;
    // R9 reset clears valid bits
    chk(!pipe_a_valid_o && !pipe_b_valid_o, "R9 reset valid", {30'd0, pipe_a_valid_o, pipe_b_valid_o}, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        for (int p = 0; p < 4; p++)
          for (int vv = 0; vv < 4; vv++)
            for (int rdy = 0; rdy < 2; rdy++) begin
              logic [4:0] rd0, r1, r2;
              int c0, c1, exp_n;
              bit v0, v1, w0, haz, clash, is1, a0, b0, a1, b1, ea, eb;
              logic [ILEN-1:0] w_0, w_1, xa, xb;
              string tag;

              @(negedge clk_i);
              rd0 = (p == 3) ? 5'd0 : 5'd5;
              r1  = (p == 1) ? 5'd5 : ((p == 3) ? 5'd0 : 5'd6);
              r2  = (p == 2) ? 5'd5 : ((p == 3) ? 5'd0 : 5'd7);
              w_0 = mk(opc_at(i), rd0, 5'd1, 5'd2);
              w_1 = mk(opc_at(j), 5'd9, r1, r2);
              v0 = vv[0];
              v1 = vv[1];
              inst0_i = w_0;
              inst1_i = w_1;
              inst0_valid_i = v0;
              inst1_valid_i = v1;
              ready_i = rdy[0];

              c0 = cls_at(i);
              c1 = cls_at(j);
              w0 = (i == 0 || i == 1 || i == 3) && rd0 != 0;
              haz = w0 && ((c1 != 3 && r1 == rd0) || ((j == 0 || j == 2 || j == 4) && r2 == rd0));
              clash = (c0 == c1) && (c0 == 1 || c0 == 2);
              is1 = rdy[0] && v0 && v1 && c0 != 1 && !clash && !haz;
              exp_n = (rdy[0] && v0) ? (is1 ? 2 : 1) : 0;

              if (!rdy[0])        tag = "R8 count";
              else if (!v0)       tag = "R7 empty slot0";
              else if (c0 == 1)   tag = "R7 branch hold";
              else if (c0 == 3)   tag = "R1 nop slot0";
              else if (clash)     tag = "R5 same pipe";
              else if (haz)       tag = "R6 dependency";
              else                tag = "R4 pair count";

              #2;
              chk(consumed_o == exp_n[1:0], tag, {30'd0, consumed_o}, exp_n);

              a0 = rdy[0] && v0 && (c0 == 1 || (c0 == 0 && !(is1 && c1 == 1)));
              b0 = rdy[0] && v0 && (c0 == 2 || (c0 == 0 && is1 && c1 == 1));
              a1 = is1 && (c1 == 1 || (c1 == 0 && !a0));
              b1 = is1 && (c1 == 2 || (c1 == 0 && a0));
              ea = a0 || a1;
              eb = b0 || b1;
              xa = a1 ? w_1 : w_0;
              xb = b1 ? w_1 : w_0;

              @(posedge clk_i);
              #1;
              // R9 outputs follow the pair one clock later
              chk(pipe_a_valid_o == ea, "R3 pipe A valid", {31'd0, pipe_a_valid_o}, {31'd0, ea});
              chk(pipe_b_valid_o == eb, "R3 pipe B valid", {31'd0, pipe_b_valid_o}, {31'd0, eb});
              if (ea) chk(pipe_a_inst_o == xa, "R2 pipe A word", pipe_a_inst_o, xa);
              if (eb) chk(pipe_b_inst_o == xb, "R2 pipe B word", pipe_b_inst_o, xb);
            end

    @(negedge clk_i);
    ready_i = 1'b0;
    @(posedge clk_i);
    #1;
    chk(!pipe_a_valid_o && !pipe_b_valid_o, "R8 idle after not ready", {30'd0, pipe_a_valid_o, pipe_b_valid_o}, '0);
    finish_run();
  end
endmodule